// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks a pre-divider and a feedback divider for a clock synthesizer. A start pulse captures a target output rate and a reference rate. The block then walks the pre-divider candidates one at a time and keeps the legal pair whose output rate lands closest to the target. All rates are integer hertz. Nothing about the oscillator itself is modelled. The search only computes divider settings.

Each candidate costs two passes through one shared serial divider. The first pass divides the reference by the candidate, which gives the step rate and shows whether the division is exact. The second pass divides the target by the step rate, which gives the feedback value. The achieved rate is the feedback value times the step rate. Because the feedback value is a truncated quotient, the achieved rate never exceeds the target, so the error is simply the target minus the achieved rate.

When the search finishes, the block raises `done` and holds the result steady until the next accepted start. If no candidate is legal, it raises `noFit` and drives zero on the divider and rate outputs.

Top module: `fbdiv_search`

## Requirements
- R1: A target above 1,000,000,000 is treated as exactly 1,000,000,000.
- R2: Pre-divider candidates are tried from 1 up to 12 in increasing order. A candidate that does not divide the reference exactly is skipped. A reference of zero has no usable candidate.
- R3: For each usable candidate p, the feedback value is floor(target * p / reference).
- R4: A feedback value below 12, above 511, or equal to 15 makes the candidate illegal.
- R5: For a legal candidate, the achieved rate is feedback * reference / p. Its error is the absolute difference between the achieved rate and the target.
- R6: A legal candidate with zero error ends the search at once. The block then finishes sooner than a search that visits all twelve candidates.
- R7: Otherwise a legal candidate replaces the best so far only when its error is strictly smaller. On equal errors the smaller pre-divider is kept.
- R8: The feedback value goes out on two ports. `fbHi` carries bit 8 and `fbLo` carries bits 7..0. `preDiv` is 5 bits wide and unsigned.
- R9: If no candidate is legal, `done` rises with `noFit`=1, and `preDiv`, `fbHi`, `fbLo` and `rateHz` all read zero.
- R10: A start pulse that arrives while a search is running is ignored. The running search finishes with the inputs it captured at its own start.
- R11: After reset, `done`, `noFit` and all result outputs are 0. `done` drops in the cycle after a start is accepted. The results and `done` stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; ignored while a search is running |
| targetHz | input | 32 | Wanted output rate in Hz |
| refHz | input | 32 | Reference rate in Hz |
| preDiv | output | 5 | Chosen pre-divider |
| fbHi | output | 1 | Bit 8 of the chosen feedback divider |
| fbLo | output | 8 | Bits 7..0 of the chosen feedback divider |
| rateHz | output | 32 | Achieved output rate in Hz |
| done | output | 1 | Result valid; held until the next accepted start |
| noFit | output | 1 | No legal candidate was found |

## Verification
The bench sweeps a grid of references against a set of targets. The references include common crystal rates, a prime, zero and the all-ones value. The targets include zero, one, values just below and above the clamp, and pseudo-random values. Each result is compared with a direct arithmetic model.

Several cases are chosen to isolate one rule each:
- A reference where the first legal candidate would give a feedback of 15, which separates the excluded-value rule from the range limits.
- A target that needs a feedback above 255, which proves that bit 8 is placed correctly.
- A pair of runs above and at the clamp, which shows the clamp takes effect.
- An exact hit at the first pre-divider against a full sweep, which shows the early stop through latency alone.
- A second start sent during a search, which separates "ignored" from "restarted".

// File: rtl/fbdiv_search_pkg.sv
package fbdiv_search_pkg;

  // One-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic load;      // capture inputs, reset the best-so-far
    logic divRef;    // start reference / candidate division
    logic divTgt;    // start target / step-rate division
    logic evaluate;  // score the current candidate
    logic stepP;     // advance to the next candidate
    logic finish;    // publish the result
  } ctlStrobe_t;

endpackage

// File: rtl/fbdiv_search_div.sv
module fbdiv_search_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     quoR, remR, divsR;
  logic [CNT_W-1:0] cntR;
  logic             busyR, doneR;
  logic [W:0]       remShift, diff;
  logic             fits;

  // Restoring division step: one quotient bit per cycle
  always_comb begin
    remShift = {remR, quoR[W-1]};
    diff     = remShift - {1'b0, divsR};
    fits     = remShift >= {1'b0, divsR};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoR  <= '0;
      remR  <= '0;
      divsR <= '0;
      cntR  <= '0;
      busyR <= 1'b0;
      doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (start && !busyR) begin
        quoR  <= dividend;
        remR  <= '0;
        divsR <= divisor;
        cntR  <= CNT_W'(W);
        busyR <= 1'b1;
      end else if (busyR) begin
        remR <= fits ? diff[W-1:0] : remShift[W-1:0];
        quoR <= {quoR[W-2:0], fits};
        cntR <= cntR - 1'b1;
        if (cntR == CNT_W'(1)) begin
          busyR <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign busy      = busyR;
  assign done      = doneR;
  assign quotient  = quoR;
  assign remainder = remR;

  AST_DIV_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busyR) |=> busyR);                                  // R3
  AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    (doneR && divsR != '0) |-> remR < divsR);                      // R3

endmodule

// File: rtl/fbdiv_search_ctrl.sv
module fbdiv_search_ctrl
  import fbdiv_search_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       divDone,
  input  logic       refDivides,
  input  logic       fbExact,
  input  logic       lastCand,
  output ctlStrobe_t strb
);
  typedef enum logic [2:0] {
    S_IDLE, S_REF, S_REFW, S_TGT, S_TGTW, S_EVAL, S_NEXT, S_FIN
  } state_t;

  state_t stateR, stateNx;

  always_comb begin
    stateNx = stateR;
    strb    = '0;
    unique case (stateR)
      S_IDLE: if (start) begin strb.load = 1'b1; stateNx = S_REF; end
      S_REF:  begin strb.divRef = 1'b1; stateNx = S_REFW; end
      S_REFW: if (divDone) stateNx = refDivides ? S_TGT : S_NEXT;
      S_TGT:  begin strb.divTgt = 1'b1; stateNx = S_TGTW; end
      S_TGTW: if (divDone) stateNx = S_EVAL;
      S_EVAL: begin strb.evaluate = 1'b1; stateNx = fbExact ? S_FIN : S_NEXT; end
      S_NEXT: begin
        if (lastCand) stateNx = S_FIN;
        else begin strb.stepP = 1'b1; stateNx = S_REF; end
      end
      S_FIN:  begin strb.finish = 1'b1; stateNx = S_IDLE; end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateR <= S_IDLE;
    else       stateR <= stateNx;
  end

  AST_EXACT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (stateR == S_EVAL && fbExact) |=> stateR == S_FIN);            // R6
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (stateR == S_NEXT && lastCand) |=> stateR == S_FIN);           // R2

endmodule

// File: rtl/fbdiv_search_path.sv
module fbdiv_search_path
  import fbdiv_search_pkg::*;
#(
  parameter int RATE_W   = 32,
  parameter int MAX_RATE = 1000000000,
  parameter int P_MAX    = 12,
  parameter int PRE_W    = 5,
  parameter int FB_W     = 9,
  parameter int FB_MIN   = 12,
  parameter int FB_MAX   = 511,
  parameter int FB_SKIP  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [RATE_W-1:0] targetHz,
  input  logic [RATE_W-1:0] refHz,
  output logic              divDone,
  output logic              refDivides,
  output logic              fbExact,
  output logic              lastCand,
  output logic [PRE_W-1:0]  preDivO,
  output logic [FB_W-1:0]   fbO,
  output logic [RATE_W-1:0] rateO,
  output logic              doneO,
  output logic              noFitO
);
  localparam logic [RATE_W-1:0] CLAMP  = RATE_W'(MAX_RATE);
  localparam logic [PRE_W-1:0]  LAST_P = PRE_W'(P_MAX);
  localparam logic [RATE_W-1:0] FBLO   = RATE_W'(FB_MIN);
  localparam logic [RATE_W-1:0] FBHI   = RATE_W'(FB_MAX);
  localparam logic [RATE_W-1:0] FBX    = RATE_W'(FB_SKIP);
  localparam int PROD_W = RATE_W + FB_W;

  logic [RATE_W-1:0] tgtR, refR, stepQ;
  logic [PRE_W-1:0]  candR, bestP;
  logic [FB_W-1:0]   bestFb;
  logic [RATE_W-1:0] bestRate, bestErr;
  logic              found, refPhase;

  logic              divBusy;
  logic [RATE_W-1:0] divQuo, divRem, divA, divB;
  logic              fbOk;
  logic [FB_W-1:0]   candFb;
  logic [PROD_W-1:0] prodW;
  logic [RATE_W-1:0] candRate, candErr;

  // One shared divider serves both passes of a candidate
  assign divA = strb.divRef ? refR : tgtR;
  assign divB = strb.divRef ? {{(RATE_W-PRE_W){1'b0}}, candR} : stepQ;

  fbdiv_search_div #(.W(RATE_W)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .start    (strb.divRef | strb.divTgt),
    .dividend (divA),
    .divisor  (divB),
    .busy     (divBusy),
    .done     (divDone),
    .quotient (divQuo),
    .remainder(divRem)
  );

  // Exact division with a nonzero step rate; a zero reference never qualifies
  assign refDivides = (divRem == '0) && (divQuo != '0);

  // Candidate scoring: the feedback value is floor(target / (ref / p))
  always_comb begin
    fbOk     = (divQuo >= FBLO) && (divQuo <= FBHI) && (divQuo != FBX);
    candFb   = divQuo[FB_W-1:0];
    prodW    = {{RATE_W{1'b0}}, candFb} * {{FB_W{1'b0}}, stepQ};
    candRate = prodW[RATE_W-1:0];
    candErr  = tgtR - candRate;
  end
  assign fbExact  = fbOk && (candErr == '0);
  assign lastCand = (candR == LAST_P);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtR <= '0; refR <= '0; stepQ <= '0; candR <= PRE_W'(1);
      bestP <= '0; bestFb <= '0; bestRate <= '0; bestErr <= '1;
      found <= 1'b0; refPhase <= 1'b0;
      preDivO <= '0; fbO <= '0; rateO <= '0; doneO <= 1'b0; noFitO <= 1'b0;
    end else begin
      if (strb.load) begin
        tgtR     <= (targetHz > CLAMP) ? CLAMP : targetHz;
        refR     <= refHz;
        candR    <= PRE_W'(1);
        bestP    <= '0;
        bestFb   <= '0;
        bestRate <= '0;
        bestErr  <= '1;
        found    <= 1'b0;
        doneO    <= 1'b0;
      end
      if (strb.divRef) refPhase <= 1'b1;
      if (strb.divTgt) refPhase <= 1'b0;
      if (divDone && refPhase) stepQ <= divQuo;
      if (strb.evaluate && fbOk && (candErr < bestErr)) begin
        bestP    <= candR;
        bestFb   <= candFb;
        bestRate <= candRate;
        bestErr  <= candErr;
        found    <= 1'b1;
      end
      if (strb.stepP) candR <= candR + 1'b1;
      if (strb.finish) begin
        doneO   <= 1'b1;
        noFitO  <= !found;
        preDivO <= found ? bestP : '0;
        fbO     <= found ? bestFb : '0;
        rateO   <= found ? bestRate : '0;
      end
    end
  end

  AST_TARGET_CLAMPED: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> tgtR <= CLAMP);                                   // R1
  AST_CAND_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (candR >= PRE_W'(1)) && (candR <= LAST_P));                     // R2
  AST_PRE_DIVIDES: assert property (@(posedge clk) disable iff (!rstN)
    (doneO && !noFitO) |-> (preDivO != '0) &&
      (refR % {{(RATE_W-PRE_W){1'b0}}, preDivO} == '0));            // R2
  AST_FB_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (doneO && !noFitO) |-> (fbO >= FB_W'(FB_MIN)) &&
      (fbO != FB_W'(FB_SKIP)));                                     // R4
  AST_RATE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (doneO && !noFitO) |-> rateO <= tgtR);                          // R5
  AST_NOFIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (doneO && noFitO) |-> (preDivO == '0) && (fbO == '0) &&
      (rateO == '0));                                               // R9
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(tgtR) && $stable(refR));                 // R10
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (doneO && !strb.load) |=> doneO && $stable(rateO) &&
      $stable(fbO));                                                // R11

endmodule

// File: rtl/fbdiv_search.sv
module fbdiv_search
  import fbdiv_search_pkg::*;
#(
  parameter int RATE_W   = 32,
  parameter int MAX_RATE = 1000000000,
  parameter int P_MAX    = 12,
  parameter int PRE_W    = 5,
  parameter int FB_W     = 9,
  parameter int FB_MIN   = 12,
  parameter int FB_MAX   = 511,
  parameter int FB_SKIP  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [RATE_W-1:0] targetHz,
  input  logic [RATE_W-1:0] refHz,
  output logic [PRE_W-1:0]  preDiv,
  output logic              fbHi,
  output logic [FB_W-2:0]   fbLo,
  output logic [RATE_W-1:0] rateHz,
  output logic              done,
  output logic              noFit
);
  ctlStrobe_t      strb;
  logic            divDone, refDivides, fbExact, lastCand;
  logic [FB_W-1:0] fbFull;

  fbdiv_search_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .divDone   (divDone),
    .refDivides(refDivides),
    .fbExact   (fbExact),
    .lastCand  (lastCand),
    .strb      (strb)
  );

  fbdiv_search_path #(
    .RATE_W(RATE_W), .MAX_RATE(MAX_RATE), .P_MAX(P_MAX), .PRE_W(PRE_W),
    .FB_W(FB_W), .FB_MIN(FB_MIN), .FB_MAX(FB_MAX), .FB_SKIP(FB_SKIP)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .targetHz  (targetHz),
    .refHz     (refHz),
    .divDone   (divDone),
    .refDivides(refDivides),
    .fbExact   (fbExact),
    .lastCand  (lastCand),
    .preDivO   (preDiv),
    .fbO       (fbFull),
    .rateO     (rateHz),
    .doneO     (done),
    .noFitO    (noFit)
  );

  // Feedback value split into its top bit and the byte below it
  assign fbHi = fbFull[FB_W-1];
  assign fbLo = fbFull[FB_W-2:0];

endmodule

// File: tb/fbdiv_search_bench.sv
`timescale 1ns/1ps
module fbdiv_search_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] targetHz = '0, refHz = '0;
  logic [4:0]  preDiv;
  logic        fbHi;
  logic [7:0]  fbLo;
  logic [31:0] rateHz;
  logic        done, noFit;

  int checks = 0;
  int errs = 0;
  longint cycles = 0;

  always #2.5 clk = ~clk;

  fbdiv_search u_fbdiv_search (
    .clk(clk), .rstN(rstN), .start(start), .targetHz(targetHz),
    .refHz(refHz), .preDiv(preDiv), .fbHi(fbHi), .fbLo(fbLo),
    .rateHz(rateHz), .done(done), .noFit(noFit)
  );

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 195000) begin
      checks++; errs++;
      $display("FAIL watchdog: run exceeded cycle budget (actual %0d, expected < 195000)", cycles);
      finishRun();
    end
  end

  // Arithmetic model of the search
  task automatic model(input longint unsigned tIn, input longint unsigned r,
                       output int unsigned p, output int unsigned fb,
                       output longint unsigned rate, output logic nf);
    longint unsigned t, bestE, f, rt, e;
    t = (tIn > 64'd1000000000) ? 64'd1000000000 : tIn;
    bestE = 64'hFFFF_FFFF_FFFF; p = 0; fb = 0; rate = 0; nf = 1'b1;
    for (int unsigned c = 1; c <= 12; c++) begin
      if (r == 0) continue;
      if (r % c != 0) continue;
      f = t * c / r;
      if (f < 12 || f > 511 || f == 15) continue;
      rt = f * r / c;
      e = (t >= rt) ? t - rt : rt - t;
      if (e == 0) begin p = c; fb = int'(f); rate = rt; nf = 1'b0; break; end
      else if (e < bestE) begin p = c; fb = int'(f); rate = rt; nf = 1'b0; bestE = e; end
    end
  endtask

  task automatic waitDone(output int lat);
    lat = 1;
    while (!done && lat < 3000) begin @(negedge clk); lat++; end
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog R11: done never rose (actual 0, expected 1)");
    end
  endtask

  task automatic runVec(input logic [31:0] t, input logic [31:0] r, output int lat);
    @(negedge clk); targetHz = t; refHz = r; start = 1'b1;
    @(negedge clk); start = 1'b0;
    checks++;
    if (done !== 1'b0) begin
      errs++; $display("FAIL R11: done after accepted start actual %b expected 0", done);
    end
    waitDone(lat);
  endtask

  task automatic checkRes(input string tag, input logic [31:0] t, input logic [31:0] r);
    int unsigned p, fb; longint unsigned rate; logic nf;
    model(t, r, p, fb, rate, nf);
    checks++;
    if (preDiv !== p[4:0] || {fbHi, fbLo} !== fb[8:0] || rateHz !== rate[31:0] || noFit !== nf) begin
      errs++;
      $display("FAIL %s t=%0d r=%0d: actual p=%0d fb=%0d rate=%0d nf=%b expected p=%0d fb=%0d rate=%0d nf=%b",
               tag, t, r, preDiv, {fbHi, fbLo}, rateHz, noFit, p, fb, rate, nf);
    end
  endtask

  initial begin
    int lat, latFull, latExact;
    logic [31:0] refs [10];
    logic [31:0] tgts [12];
    logic [31:0] lcg;
    logic [31:0] keepRate; logic [8:0] keepFb;

    refs = '{32'd24000000, 32'd27000000, 32'd19200000, 32'd12000000, 32'd26000000,
             32'd50000000, 32'd1000000, 32'd7, 32'd0, 32'hFFFFFFFF};
    tgts = '{32'd0, 32'd1, 32'd99999999, 32'd297000000, 32'd480000000, 32'd500000007,
             32'd733333333, 32'd999999999, 32'd1000000000, 32'd1500000000, 32'd0, 32'd0};
    lcg = 32'd12345;
    for (int k = 10; k < 12; k++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      tgts[k] = lcg % 32'd1100000000;
    end

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    checks++;
    if (done !== 1'b0 || noFit !== 1'b0 || preDiv !== '0 || {fbHi, fbLo} !== '0 || rateHz !== '0) begin
      errs++;
      $display("FAIL R11 reset: actual done=%b nf=%b p=%0d fb=%0d rate=%0d expected all 0",
               done, noFit, preDiv, {fbHi, fbLo}, rateHz);
    end

    // R2 R3 R5 R7 R9: grid sweep against the model
    foreach (refs[i]) begin
      foreach (tgts[j]) begin
        runVec(tgts[j], refs[i], lat);
        checkRes("R2 R3 R5 R7 R9 sweep", tgts[j], refs[i]);
      end
    end

    // R4: fb of 15 at p=1 must be skipped; p=2 gives an exact fb of 30
    runVec(32'd150000000, 32'd10000000, lat);
    checkRes("R4 skip-15", 32'd150000000, 32'd10000000);
    checks++;
    if (preDiv !== 5'd2) begin
      errs++; $display("FAIL R4: preDiv actual %0d expected 2", preDiv);
    end

    // R8: fb of 400 puts bit 8 on fbHi and 144 on fbLo
    runVec(32'd400000000, 32'd1000000, lat);
    checks++;
    if (fbHi !== 1'b1 || fbLo !== 8'd144 || preDiv !== 5'd1) begin
      errs++; $display("FAIL R8: actual hi=%b lo=%0d p=%0d expected hi=1 lo=144 p=1", fbHi, fbLo, preDiv);
    end

    // R1: target above the clamp behaves like the clamp value
    runVec(32'd1000000000, 32'd26000000, lat);
    keepRate = rateHz; keepFb = {fbHi, fbLo};
    runVec(32'd3000000000, 32'd26000000, lat);
    checks++;
    if (rateHz !== keepRate || {fbHi, fbLo} !== keepFb) begin
      errs++; $display("FAIL R1: clamped actual rate=%0d fb=%0d expected rate=%0d fb=%0d",
                       rateHz, {fbHi, fbLo}, keepRate, keepFb);
    end

    // R9: prime reference gives no fit
    runVec(32'd100000000, 32'd7, lat);
    checks++;
    if (noFit !== 1'b1 || rateHz !== '0 || preDiv !== '0) begin
      errs++; $display("FAIL R9: actual nf=%b rate=%0d p=%0d expected nf=1 rate=0 p=0", noFit, rateHz, preDiv);
    end

    // R6: exact hit at p=1 finishes much sooner than a full sweep
    runVec(32'd24000000 * 32'd20, 32'd24000000, latExact);
    checkRes("R6 exact", 32'd480000000, 32'd24000000);
    runVec(32'd100000000, 32'd7, latFull);
    checks++;
    if (latExact * 4 >= latFull) begin
      errs++; $display("FAIL R6: exact latency actual %0d expected < %0d", latExact, latFull / 4);
    end

    // R10: second start during a search is ignored
    @(negedge clk); targetHz = 32'd733333333; refHz = 32'd27000000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    targetHz = 32'd297000000; refHz = 32'd12000000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    targetHz = 32'd5; refHz = 32'd5;
    waitDone(lat);
    checkRes("R10 busy-start", 32'd733333333, 32'd27000000);

    // R11: result and done hold while idle, even as inputs change
    keepRate = rateHz; keepFb = {fbHi, fbLo};
    repeat (7) @(negedge clk);
    checks++;
    if (done !== 1'b1 || rateHz !== keepRate || {fbHi, fbLo} !== keepFb) begin
      errs++; $display("FAIL R11 hold: actual done=%b rate=%0d fb=%0d expected done=1 rate=%0d fb=%0d",
                       done, rateHz, {fbHi, fbLo}, keepRate, keepFb);
    end

    finishRun();
  end
endmodule